// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by searching a hashed page table that lives in ordinary memory. It is given a 24-bit virtual segment identifier and the 28-bit offset of the effective address inside its 256 MiB segment. From these it derives a 16-bit page index for 4 KiB pages, a hash and a compare tag. It then reads candidate entries through a single word-wide memory port. First it scans the primary group of eight entries. If that fails, it scans the group addressed by the bitwise complement of the hash.

Each table entry is two 32-bit words, eight bytes in all. The walker reads word 0 before word 1. It accepts the first entry in increasing slot order whose valid bit is set, whose hash-select bit equals the pass number and whose tag field matches. On a hit it sets the referenced flag and, for a store, the changed flag. Each flag is set by a one-byte store that reuses the memory port. The walker then reports the entry words, the entry offset inside the table, the real address and a write-inhibit flag. The write-inhibit flag makes a later write come back through the walk so that the changed flag gets set. Permission checks and fault reporting are left to the caller.

Top module: `hpt_walker`

## Requirements
- R1: The hash is VSID XOR the zero-extended page index, where the page index is `walk_seg_off[27:12]`. The primary group offset is `(hash << 6) & tbl_mask`. The compare tag puts the VSID in word-0 bits 30:7 and page index bits 15:10 in word-0 bits 5:0.
- R2: Word 0 of an entry matches only when bit 31 (valid) is 1, bit 6 (hash select) equals the pass (0 primary, 1 secondary), and bits 30:7 and 5:0 equal the tag.
- R3: Slots are read in increasing order at `tbl_base + group_offset + 8*slot`, and the first matching slot ends the search.
- R4: The secondary pass begins only after all eight primary slots miss. It uses the group offset `(~hash << 6) & tbl_mask` with a 32-bit complement.
- R5: When all 16 entries miss, the result has `res_found` = 0 and `res_offset`, `res_word0`, `res_word1` and `res_raddr` at zero. The walk makes exactly 32 reads and no writes.
- R6: For every entry, word 0 (entry address) is read and its response received before word 1 (entry address + 4) is requested.
- R7: On a hit whose word-1 bit 8 (referenced) is 0, one write goes to the entry address + 4. The write has byte enable 4'b0010 (lane bits 15:8, which is entry byte 6), and its data bits 15:8 are word-1 bits 15:8 with bit 0 set.
- R8: On a hit for a store whose word-1 bit 7 (changed) is 0, one write goes to the entry address + 4. The write has byte enable 4'b0001 (entry byte 7), and its data bits 7:0 are word-1 bits 7:0 with bit 7 set. This write follows the referenced write when both are due.
- R9: `res_wr_inhibit` is 1 exactly when the entry is found, its changed bit is 0 and the access is not a store.
- R10: On a hit, `res_raddr` is word-1 bits 31:12 followed by `walk_seg_off[11:0]`. `res_offset` is the entry offset from `tbl_base`, and the word outputs hold the words as they were read. `res_valid` is a one-cycle pulse.
- R11: A memory request holds its address and kind until `mem_req_ready`. Every accepted request, read or write, gets one `mem_rsp_valid` in a later cycle. `walk_ready` is high only while no memory request is pending.
- R12: After reset, `walk_ready` = 1, `res_valid` = 0 and `mem_req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| walk_valid | input | 1 | Start a walk |
| walk_ready | output | 1 | Walker idle, start accepted |
| walk_vsid | input | 24 | Virtual segment identifier |
| walk_seg_off | input | 28 | Effective address offset inside the segment |
| walk_store | input | 1 | Access is a store |
| tbl_base | input | ADDR_W | Table base address |
| tbl_mask | input | ADDR_W | Table size mask applied to group offsets |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | ADDR_W | Byte address, word aligned |
| mem_req_we | output | 1 | Request is a write |
| mem_req_be | output | 4 | Byte lanes for a write, bit 3 = bits 31:24 |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rsp_data | input | 32 | Read data |
| res_valid | output | 1 | Result pulse |
| res_found | output | 1 | Matching entry found |
| res_offset | output | ADDR_W | Entry offset from the table base |
| res_word0 | output | 32 | Entry word 0 as read |
| res_word1 | output | 32 | Entry word 1 as read |
| res_raddr | output | 32 | Real address |
| res_wr_inhibit | output | 1 | Write permission withheld |

## Verification
The embedded properties check the port protocol on every cycle: requests hold while stalled, byte stores use a single lane, word 1 is never requested before word 0 of the same entry has returned, and idle excludes traffic. They also check the result: a reported hit carries a valid word 0 whose select bit equals the final pass, a miss occurs only after all sixteen probes, and write-inhibit follows the changed bit and the access kind. Only the bench scenarios can show the rest. These are the hash and complement arithmetic, the slot order and first-match choice, the decoys that must be skipped, the exact bytes written back to memory, and the read counts per walk.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
    localparam int unsigned VSID_W     = 24;
    localparam int unsigned PIDX_W     = 16;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned SEG_OFF_W  = PAGE_SHIFT + PIDX_W;
    localparam int unsigned API_W      = 6;
    localparam int unsigned ENTRY_BYTES = 8;

    localparam int unsigned V_BIT = 31;
    localparam int unsigned H_BIT = 6;
    localparam int unsigned R_BIT = 8;
    localparam int unsigned C_BIT = 7;

    localparam logic [31:0] TAG_FIELDS = 32'h7FFF_FFBF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD0_W,
        ST_RD1,
        ST_RD1_W,
        ST_CHECK,
        ST_SETR,
        ST_SETR_W,
        ST_SETC,
        ST_SETC_W,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/hpt_hash.sv
`timescale 1ns/1ps
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned GROUP_SHIFT = 6
) (
    input  logic [VSID_W-1:0] vsid_i,
    input  logic [PIDX_W-1:0] pidx_i,
    input  logic              pass_i,
    input  logic [ADDR_W-1:0] mask_i,
    output logic [31:0]       tag_o,
    output logic [ADDR_W-1:0] group_off_o
);
    logic [ADDR_W-1:0] hash;
    logic [ADDR_W-1:0] sel;

    always_comb begin
        hash        = ADDR_W'(vsid_i ^ VSID_W'(pidx_i));
        sel         = pass_i ? ~hash : hash;
        group_off_o = (sel << GROUP_SHIFT) & mask_i;
        tag_o       = {1'b0, vsid_i, 1'b0, pidx_i[PIDX_W-1 -: API_W]};
    end
endmodule

// File: rtl/hpt_match.sv
`timescale 1ns/1ps
module hpt_match
    import hpt_pkg::*;
(
    input  logic [31:0] word0_i,
    input  logic [31:0] tag_i,
    input  logic        pass_i,
    output logic        hit_o
);
    always_comb begin
        hit_o = word0_i[V_BIT]
             && (word0_i[H_BIT] == pass_i)
             && ((word0_i & TAG_FIELDS) == tag_i);
    end
endmodule

// File: rtl/hpt_walker.sv
`timescale 1ns/1ps
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned GROUP_ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 walk_valid,
    output logic                 walk_ready,
    input  logic [VSID_W-1:0]    walk_vsid,
    input  logic [SEG_OFF_W-1:0] walk_seg_off,
    input  logic                 walk_store,
    input  logic [ADDR_W-1:0]    tbl_base,
    input  logic [ADDR_W-1:0]    tbl_mask,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [ADDR_W-1:0]    mem_req_addr,
    output logic                 mem_req_we,
    output logic [3:0]           mem_req_be,
    output logic [31:0]          mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [31:0]          mem_rsp_data,
    output logic                 res_valid,
    output logic                 res_found,
    output logic [ADDR_W-1:0]    res_offset,
    output logic [31:0]          res_word0,
    output logic [31:0]          res_word1,
    output logic [31:0]          res_raddr,
    output logic                 res_wr_inhibit
);
    localparam int unsigned IDX_W       = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
    localparam int unsigned SLOT_SHIFT  = $clog2(ENTRY_BYTES);
    localparam int unsigned GROUP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
    localparam int unsigned MAX_PROBES  = 2 * GROUP_ENTRIES;
    localparam int unsigned PROBE_W     = $clog2(MAX_PROBES + 1) + 1;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(GROUP_ENTRIES - 1);

    typedef struct packed {
        walk_state_e          st;
        logic [VSID_W-1:0]    vsid;
        logic [SEG_OFF_W-1:0] soff;
        logic                 store;
        logic                 pass;
        logic [IDX_W-1:0]     idx;
        logic [31:0]          w0;
        logic [31:0]          w1;
        logic                 found;
        logic                 inhibit;
        logic                 w0_ok;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [31:0]       tag;
    logic [ADDR_W-1:0] group_off;
    logic [ADDR_W-1:0] entry_off;
    logic [ADDR_W-1:0] entry_addr;
    logic              hit;

    hpt_hash #(
        .ADDR_W      (ADDR_W),
        .GROUP_SHIFT (GROUP_SHIFT)
    ) u_hash (
        .vsid_i      (q.vsid),
        .pidx_i      (q.soff[SEG_OFF_W-1:PAGE_SHIFT]),
        .pass_i      (q.pass),
        .mask_i      (tbl_mask),
        .tag_o       (tag),
        .group_off_o (group_off)
    );

    hpt_match u_match (
        .word0_i (q.w0),
        .tag_i   (tag),
        .pass_i  (q.pass),
        .hit_o   (hit)
    );

    always_comb begin
        entry_off  = group_off + (ADDR_W'(q.idx) << SLOT_SHIFT);
        entry_addr = tbl_base + entry_off;

        d             = q;
        walk_ready    = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = entry_addr;
        mem_req_we    = 1'b0;
        mem_req_be    = 4'b0000;
        mem_req_wdata = 32'h0;

        unique case (q.st)
            ST_IDLE: begin
                walk_ready = 1'b1;
                if (walk_valid) begin
                    d.vsid    = walk_vsid;
                    d.soff    = walk_seg_off;
                    d.store   = walk_store;
                    d.pass    = 1'b0;
                    d.idx     = '0;
                    d.found   = 1'b0;
                    d.inhibit = 1'b0;
                    d.st      = ST_RD0;
                end
            end
            ST_RD0: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    d.w0_ok = 1'b0;
                    d.st    = ST_RD0_W;
                end
            end
            ST_RD0_W: begin
                if (mem_rsp_valid) begin
                    d.w0    = mem_rsp_data;
                    d.w0_ok = 1'b1;
                    d.st    = ST_RD1;
                end
            end
            ST_RD1: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = entry_addr + ADDR_W'(4);
                if (mem_req_ready) d.st = ST_RD1_W;
            end
            ST_RD1_W: begin
                if (mem_rsp_valid) begin
                    d.w1 = mem_rsp_data;
                    d.st = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (hit) begin
                    d.found   = 1'b1;
                    d.inhibit = !q.w1[C_BIT] && !q.store;
                    if (!q.w1[R_BIT])                     d.st = ST_SETR;
                    else if (!q.w1[C_BIT] && q.store)     d.st = ST_SETC;
                    else                                  d.st = ST_DONE;
                end else if (q.idx != LAST_SLOT) begin
                    d.idx = q.idx + 1'b1;
                    d.st  = ST_RD0;
                end else if (!q.pass) begin
                    d.pass = 1'b1;
                    d.idx  = '0;
                    d.st   = ST_RD0;
                end else begin
                    d.found = 1'b0;
                    d.st    = ST_DONE;
                end
            end
            ST_SETR: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = entry_addr + ADDR_W'(4);
                mem_req_we    = 1'b1;
                mem_req_be    = 4'b0010;
                mem_req_wdata = {16'h0, q.w1[15:8] | 8'h01, 8'h00};
                if (mem_req_ready) d.st = ST_SETR_W;
            end
            ST_SETR_W: begin
                if (mem_rsp_valid) d.st = (!q.w1[C_BIT] && q.store) ? ST_SETC : ST_DONE;
            end
            ST_SETC: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = entry_addr + ADDR_W'(4);
                mem_req_we    = 1'b1;
                mem_req_be    = 4'b0001;
                mem_req_wdata = {24'h0, q.w1[7:0] | 8'h80};
                if (mem_req_ready) d.st = ST_SETC_W;
            end
            ST_SETC_W: begin
                if (mem_rsp_valid) d.st = ST_DONE;
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        res_valid      = (q.st == ST_DONE);
        res_found      = q.found;
        res_wr_inhibit = q.inhibit;
        res_offset     = q.found ? entry_off : '0;
        res_word0      = q.found ? q.w0 : 32'h0;
        res_word1      = q.found ? q.w1 : 32'h0;
        res_raddr      = q.found ? {q.w1[31:PAGE_SHIFT], q.soff[PAGE_SHIFT-1:0]} : 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // Probe counter kept for the properties below: word-0 reads since the walk began.
    logic [PROBE_W-1:0] probe_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  probe_cnt_q <= '0;
        else if (walk_valid && walk_ready)           probe_cnt_q <= '0;
        else if (q.st == ST_RD0 && mem_req_ready)    probe_cnt_q <= probe_cnt_q + 1'b1;
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_ready |-> !mem_req_valid);

    // R7
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> $countones(mem_req_be) == 1);

    // R6
    word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_we && mem_req_addr[2] |-> q.w0_ok);

    // R2
    hit_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_found |-> res_word0[V_BIT] && (res_word0[H_BIT] == q.pass));

    // R5
    miss_probes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_found |-> probe_cnt_q == PROBE_W'(MAX_PROBES));

    // R5
    probe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_cnt_q <= PROBE_W'(MAX_PROBES));

    // R9
    inhibit_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_wr_inhibit == (res_found && !res_word1[C_BIT] && !q.store));

    // R10
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
    localparam logic [31:0] BASE = 32'h0004_0000;
    localparam logic [31:0] MASK = 32'h0000_0FC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_valid = 1'b0;
    logic        walk_ready;
    logic [23:0] walk_vsid = '0;
    logic [27:0] walk_seg_off = '0;
    logic        walk_store = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_req_we;
    logic [3:0]  mem_req_be;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid, res_found, res_wr_inhibit;
    logic [31:0] res_offset, res_word0, res_word1, res_raddr;

    always #2.5 clk = ~clk;

    hpt_walker u_hpt_walker (
        .clk(clk), .rst_n(rst_n),
        .walk_valid(walk_valid), .walk_ready(walk_ready),
        .walk_vsid(walk_vsid), .walk_seg_off(walk_seg_off), .walk_store(walk_store),
        .tbl_base(BASE), .tbl_mask(MASK),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
        .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_found(res_found), .res_offset(res_offset),
        .res_word0(res_word0), .res_word1(res_word1), .res_raddr(res_raddr),
        .res_wr_inhibit(res_wr_inhibit)
    );

    logic [31:0] mem [0:1023];
    int          n_chk = 0;
    int          n_fail = 0;
    int          rd_cnt, wr_cnt, order_bad;
    logic [3:0]  first_be;
    logic [31:0] last_rd;
    bit          ended = 0;

    // captured result
    logic        c_found, c_inh;
    logic [31:0] c_off, c_w0, c_w1, c_ra;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: decides ready, accepts, answers one cycle after acceptance
    initial begin
        logic        pend;
        logic [31:0] pend_data;
        int          cyc;
        logic [9:0]  wi;
        pend = 0; pend_data = 0; cyc = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = pend;
            mem_rsp_data  = pend_data;
            pend = 0;
            cyc++;
            mem_req_ready = (cyc % 7) != 3;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                wi = 10'((mem_req_addr - BASE) >> 2);
                if (!mem_req_we) begin
                    pend_data = mem[wi];
                    rd_cnt++;
                    if (mem_req_addr[2] && last_rd != mem_req_addr - 32'd4) order_bad++;
                    last_rd = mem_req_addr;
                end else begin
                    if (mem_req_be[3]) mem[wi][31:24] = mem_req_wdata[31:24];
                    if (mem_req_be[2]) mem[wi][23:16] = mem_req_wdata[23:16];
                    if (mem_req_be[1]) mem[wi][15:8]  = mem_req_wdata[15:8];
                    if (mem_req_be[0]) mem[wi][7:0]   = mem_req_wdata[7:0];
                    wr_cnt++;
                    if (wr_cnt == 1) first_be = mem_req_be;
                    pend_data = 0;
                end
                pend = 1;
            end
        end
    end

    function automatic logic [31:0] grp(input logic [23:0] v, input logic [15:0] p, input logic pass);
        logic [31:0] h;
        h = {8'h0, v ^ {8'h0, p}};
        if (pass) h = ~h;
        return (h << 6) & MASK;
    endfunction

    function automatic logic [31:0] mk_w0(input logic valid, input logic [23:0] v, input logic h, input logic [5:0] api);
        return {valid, v, h, api};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    endtask

    task automatic put(input logic [31:0] off, input logic [31:0] w0, input logic [31:0] w1);
        mem[10'(off >> 2)]     = w0;
        mem[10'(off >> 2) + 1] = w1;
    endtask

    task automatic walk(input logic [23:0] v, input logic [27:0] so, input logic st);
        int t;
        @(negedge clk);
        while (!walk_ready) @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; order_bad = 0; first_be = 4'h0; last_rd = 32'hFFFF_FFFF;
        walk_vsid = v; walk_seg_off = so; walk_store = st; walk_valid = 1'b1;
        @(negedge clk);
        walk_valid = 1'b0;
        t = 0;
        while (!res_valid && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) begin
            n_chk++; n_fail++;
            $display("FAIL R10 walk timeout: actual %0d expected result pulse", t);
        end
        c_found = res_found; c_inh = res_wr_inhibit; c_off = res_offset;
        c_w0 = res_word0; c_w1 = res_word1; c_ra = res_raddr;
        chk("R6", "word order violations", 32'(order_bad), 32'd0);
    endtask

    initial begin
        #1_000_000;
        if (!ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic [15:0] p;
        logic [27:0] so;
        logic [31:0] g, g1, w0m, w1m, exp_w1;
        clear_mem();
        repeat (4) @(negedge clk);
        // R12 reset state
        chk("R12", "walk_ready in reset", 32'(walk_ready), 32'd1);
        chk("R12", "res_valid in reset", 32'(res_valid), 32'd0);
        chk("R12", "mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "walk_ready after reset", 32'(walk_ready), 32'd1);

        // Primary group, hit at every slot, decoys ahead (R1 R2 R3 R7 R9 R10)
        for (int k = 0; k < 8; k++) begin
            v  = 24'hFF0F00 ^ 24'(k * 24'h013579);
            p  = 16'h1234 + 16'(k * 16'h0F0F);
            so = {p, 12'(12'h100 + k)};
            clear_mem();
            g = grp(v, p, 1'b0);
            for (int j = 0; j < k; j++) begin
                if (j % 3 == 0)      put(g + 32'(8*j), mk_w0(1'b0, v, 1'b0, p[15:10]), 32'h0);
                else if (j % 3 == 1) put(g + 32'(8*j), mk_w0(1'b1, v, 1'b1, p[15:10]), 32'h0);
                else                 put(g + 32'(8*j), mk_w0(1'b1, v, 1'b0, p[15:10] ^ 6'h01), 32'h0);
            end
            w0m = mk_w0(1'b1, v, 1'b0, p[15:10]);
            w1m = {20'hABC00 + 20'(k), 12'h002};
            put(g + 32'(8*k), w0m, w1m);
            walk(v, so, 1'b0);
            chk("R2", "primary found", 32'(c_found), 32'd1);
            chk("R3", "primary offset", c_off, g + 32'(8*k));
            chk("R3", "primary read count", 32'(rd_cnt), 32'(2*(k+1)));
            chk("R10", "primary raddr", c_ra, {w1m[31:12], so[11:0]});
            chk("R10", "primary word0", c_w0, w0m);
            chk("R7", "referenced write count", 32'(wr_cnt), 32'd1);
            chk("R7", "referenced byte in memory", mem[10'((g + 32'(8*k)) >> 2) + 1], w1m | 32'h100);
            chk("R9", "inhibit on load with C clear", 32'(c_inh), 32'd1);
        end

        // Secondary group after primary misses (R4 R2)
        for (int k = 0; k < 8; k++) begin
            v  = 24'h00A5C3 + 24'(k * 24'h10203);
            p  = 16'hBEEF ^ 16'(k * 16'h0111);
            so = {p, 12'h7F0};
            clear_mem();
            g  = grp(v, p, 1'b0);
            g1 = grp(v, p, 1'b1);
            for (int j = 0; j < 8; j++) put(g + 32'(8*j), mk_w0(1'b1, v, 1'b1, p[15:10]), 32'h1111_1180);
            for (int j = 0; j < k; j++) put(g1 + 32'(8*j), mk_w0(1'b1, v, 1'b0, p[15:10]), 32'h2222_2180);
            w0m = mk_w0(1'b1, v, 1'b1, p[15:10]);
            w1m = {20'h55000 + 20'(k), 12'h181};
            put(g1 + 32'(8*k), w0m, w1m);
            walk(v, so, 1'(k % 2));
            chk("R4", "secondary found", 32'(c_found), 32'd1);
            chk("R4", "secondary offset", c_off, g1 + 32'(8*k));
            chk("R4", "secondary read count", 32'(rd_cnt), 32'(16 + 2*(k+1)));
            chk("R8", "no writes with R and C set", 32'(wr_cnt), 32'd0);
            chk("R9", "no inhibit with C set", 32'(c_inh), 32'd0);
            chk("R10", "secondary word1", c_w1, w1m);
        end

        // Full miss (R5)
        v = 24'h123456; p = 16'h00FF; so = {p, 12'h000};
        clear_mem();
        g = grp(v, p, 1'b0); g1 = grp(v, p, 1'b1);
        for (int j = 0; j < 8; j++) begin
            put(g + 32'(8*j), mk_w0(1'b1, v, 1'b1, p[15:10]), 32'hFFFF_F000);
            put(g1 + 32'(8*j), mk_w0(1'b1, v, 1'b0, p[15:10]), 32'hFFFF_F000);
        end
        walk(v, so, 1'b1);
        chk("R5", "miss found", 32'(c_found), 32'd0);
        chk("R5", "miss read count", 32'(rd_cnt), 32'd32);
        chk("R5", "miss write count", 32'(wr_cnt), 32'd0);
        chk("R5", "miss offset", c_off, 32'd0);
        chk("R5", "miss raddr", c_ra, 32'd0);

        // First match wins (R3)
        v = 24'h0C0FFE; p = 16'h4321; so = {p, 12'hFFF};
        clear_mem();
        g = grp(v, p, 1'b0);
        put(g + 32'd16, mk_w0(1'b1, v, 1'b0, p[15:10]), 32'h11111180);
        put(g + 32'd40, mk_w0(1'b1, v, 1'b0, p[15:10]), 32'h22222180);
        walk(v, so, 1'b0);
        chk("R3", "first match offset", c_off, g + 32'd16);
        chk("R3", "first match raddr", c_ra, 32'h11111FFF);

        // Referenced / changed sweep (R7 R8 R9)
        for (int rc = 0; rc < 4; rc++) begin
            for (int st = 0; st < 2; st++) begin
                logic rb, cb;
                int   ew;
                rb = rc[1]; cb = rc[0];
                v = 24'h3AB000 + 24'(rc); p = 16'h0808 + 16'(st); so = {p, 12'h345};
                clear_mem();
                g = grp(v, p, 1'b0);
                w1m = {20'h9F00F, 3'b000, rb, cb, 7'b0000011};
                put(g + 32'd24, mk_w0(1'b1, v, 1'b0, p[15:10]), w1m);
                walk(v, so, 1'(st));
                ew = (rb ? 0 : 1) + ((!cb && st == 1) ? 1 : 0);
                exp_w1 = w1m | (rb ? 32'h0 : 32'h100) | ((!cb && st == 1) ? 32'h80 : 32'h0);
                chk("R8", "flag write count", 32'(wr_cnt), 32'(ew));
                chk("R8", "flag bytes in memory", mem[10'((g + 32'd24) >> 2) + 1], exp_w1);
                chk("R9", "inhibit flag", 32'(c_inh), 32'((!cb && st == 0) ? 1 : 0));
                if (ew == 2) chk("R7", "referenced write precedes changed", 32'(first_be), 32'h2);
                chk("R10", "word1 as read", c_w1, w1m);
            end
        end

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule